// File: doc/BRIEF.md
# Flash Array Operation Sequencer

This block sits behind the serial command front end of a paged flash device. The front end hands it one decoded opcode and page address per command. For commands that use the memory array, the block runs timed phases: page-to-buffer transfer, buffer compare, erase and program. Each phase length comes from a parameter, so the timing is a count of clock cycles rather than a real delay. Some commands run two phases in turn: erase and then program, or transfer and then program. At the last cycle of each phase the block raises a one-cycle commit strobe. The array model acts on that strobe.

The block also builds the status byte. That byte holds a ready flag, the result of the latest compare and a fixed density code. The byte can be read in parallel, or one bit at a time through a small serializer that repeats the byte for as long as it is clocked. While an array operation runs, any new array command is dropped. Buffer-only commands and status reads pass through without effect. The busy condition is also driven out as the enable of an open-drain pull-down.

The block applies two inputs itself. With write protect active, a commit that would change a low page is withheld. Reset aborts any operation in progress.

Top module: `nvm_op_sequencer`

## Requirements
- R1: The status byte has bit 7 = ready (1 = idle), bit 6 = compare result, bits 5..3 = 3'b101 and bits 2..0 = 3'b000. After reset it reads 8'hA8.
- R2: An accepted array command holds status bit 7 at 0 and `busy_pull_en` at 1 for exactly the sum of its phase lengths. The two always agree. There is one `arr_commit` pulse per phase, on that phase's last cycle.
- R3: An array command that arrives while busy is dropped. The running operation keeps its length, page and phases, and the status bits do not change.
- R4: Buffer-group opcodes (0x54, 0x56, 0x84, 0x87), the status read 0x57 and undefined opcodes start no phase and leave the status byte unchanged.
- R5: Opcodes 0x83/0x82 (buffer 0) and 0x86/0x85 (buffer 1) run an erase phase of T_ERASE cycles and then a program phase of T_PROG cycles on the same page.
- R6: Opcodes 0x58 (buffer 0) and 0x59 (buffer 1) run a transfer phase of T_XFER cycles and then a program phase of T_PROG cycles on the same page.
- R7: Opcode 0x50 runs a single erase phase of T_BLK cycles. During it `arr_block` = 1 and `arr_page` has its 3 low bits cleared.
- R8: Opcodes 0x60 (buffer 0) and 0x61 (buffer 1) run a compare phase of T_XFER cycles. Status bit 6 then takes the `cmp_miss` value sampled on the last cycle of that phase and keeps it until the next compare ends.
- R9: With `wp_n` low, the commit of an erase or program phase is withheld when the page is below PROT_PAGES (256). The phase still runs its full length. Transfer and compare commits, and all pages at or above PROT_PAGES, are not affected.
- R10: `rst_n` low immediately ends any operation: the phase goes to idle, busy is released, the compare bit is cleared, and no commit follows for the aborted operation.
- R11: `st_load` points the serializer at bit 7. Each `st_shift` moves it to the next lower bit, wrapping from bit 0 to bit 7. `st_bit` always shows the live status value at that position.
- R12: `arr_phase` encodes idle 0, transfer 1, compare 2, erase 3, program 4. Opcodes 0x53/0x55 run one transfer phase (T_XFER), 0x88/0x89 one program phase (T_PROG) and 0x81 one erase phase (T_ERASE). The low opcode of each pair selects buffer 0 on `arr_buf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts any operation |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 8 | Command opcode |
| cmd_page | input | 12 | Target page address |
| wp_n | input | 1 | Active-low write protect for the low pages |
| cmp_miss | input | 1 | Mismatch flag from the array compare logic |
| st_load | input | 1 | Restart serial status readout at bit 7 |
| st_shift | input | 1 | Advance serial status readout by one bit |
| st_bit | output | 1 | Current serial status bit |
| status_o | output | 8 | Live status byte |
| busy_pull_en | output | 1 | Enable for the open-drain pull-down of the ready/busy line |
| arr_phase | output | 3 | Current array phase code |
| arr_page | output | 12 | Page of the running operation |
| arr_buf | output | 1 | Buffer used by the running operation |
| arr_block | output | 1 | Running erase covers an 8-page block |
| arr_commit | output | 1 | One-cycle strobe telling the array to apply the phase |

## Verification
If the phase register is corrupted, the busy window is the wrong length, which shows on `busy_pull_en` and status bit 7 in the same cycle. An error in the second-phase latch shows one cycle after the first phase ends, as a wrong `arr_phase` code or an early release. If the lockout leaks, a command issued mid-operation changes `arr_page` or extends the window on the very next cycle. A compare bit that is captured wrongly, or a protect gate that misses, shows up as a wrong status bit 6 after the compare, or as a wrong count of `arr_commit` pulses.

// File: rtl/nvmseq_pkg.sv
package nvmseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_XFER  = 3'd1,
    PH_CMP   = 3'd2,
    PH_ERASE = 3'd3,
    PH_PROG  = 3'd4
  } phase_e;

  typedef struct packed {
    logic   arr;     // command uses the array
    phase_e first;
    phase_e second;  // PH_IDLE when single phase
    logic   bsel;
    logic   blk;
  } plan_t;

  localparam logic [2:0] DENSITY_CODE = 3'b101;

  function automatic plan_t decode_op(input logic [7:0] op);
    plan_t p;
    p = '{arr: 1'b0, first: PH_IDLE, second: PH_IDLE, bsel: 1'b0, blk: 1'b0};
    case (op)
      8'h53, 8'h55: begin
        p.arr = 1'b1; p.first = PH_XFER; p.bsel = (op == 8'h55);
      end
      8'h60, 8'h61: begin
        p.arr = 1'b1; p.first = PH_CMP; p.bsel = (op == 8'h61);
      end
      8'h82, 8'h83, 8'h85, 8'h86: begin
        p.arr = 1'b1; p.first = PH_ERASE; p.second = PH_PROG;
        p.bsel = (op == 8'h85) || (op == 8'h86);
      end
      8'h88, 8'h89: begin
        p.arr = 1'b1; p.first = PH_PROG; p.bsel = (op == 8'h89);
      end
      8'h58, 8'h59: begin
        p.arr = 1'b1; p.first = PH_XFER; p.second = PH_PROG;
        p.bsel = (op == 8'h59);
      end
      8'h81: begin
        p.arr = 1'b1; p.first = PH_ERASE;
      end
      8'h50: begin
        p.arr = 1'b1; p.first = PH_ERASE; p.blk = 1'b1;
      end
      default: p = p;
    endcase
    return p;
  endfunction

  function automatic int unsigned phase_len(input phase_e ph, input logic blk,
                                            input int unsigned t_xfer,
                                            input int unsigned t_erase,
                                            input int unsigned t_blk,
                                            input int unsigned t_prog);
    case (ph)
      PH_XFER, PH_CMP: return t_xfer;
      PH_ERASE:        return blk ? t_blk : t_erase;
      PH_PROG:         return t_prog;
      default:         return 1;
    endcase
  endfunction

endpackage

// File: rtl/nvmseq_decode.sv
module nvmseq_decode
  import nvmseq_pkg::*;
(
  input  logic [7:0] op_i,
  output plan_t      plan_o
);
  always_comb plan_o = decode_op(op_i);
endmodule

// File: rtl/nvmseq_timer.sv
module nvmseq_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
endmodule

// File: rtl/nvmseq_status_ser.sv
module nvmseq_status_ser #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word_i,
  input  logic         load_i,
  input  logic         shift_i,
  output logic         bit_o
);
  localparam int unsigned IW = $clog2(W);
  localparam logic [IW-1:0] TOP = IW'(W - 1);

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= TOP;
    else if (load_i)   idx_q <= TOP;
    else if (shift_i)  idx_q <= (idx_q == '0) ? TOP : idx_q - 1'b1;
  end

  assign bit_o = word_i[idx_q];

  AST_SER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (idx_q == TOP)); // R11
  AST_SER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i && idx_q == '0) |=> (idx_q == TOP)); // R11
endmodule

// File: rtl/nvm_op_sequencer.sv
module nvm_op_sequencer
  import nvmseq_pkg::*;
#(
  parameter int unsigned PAGE_AW    = 12,
  parameter int unsigned BLK_SHIFT  = 3,
  parameter int unsigned PROT_PAGES = 256,
  parameter int unsigned T_XFER     = 6,
  parameter int unsigned T_ERASE    = 10,
  parameter int unsigned T_BLK      = 20,
  parameter int unsigned T_PROG     = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_op,
  input  logic [PAGE_AW-1:0] cmd_page,
  input  logic               wp_n,
  input  logic               cmp_miss,
  input  logic               st_load,
  input  logic               st_shift,
  output logic               st_bit,
  output logic [7:0]         status_o,
  output logic               busy_pull_en,
  output logic [2:0]         arr_phase,
  output logic [PAGE_AW-1:0] arr_page,
  output logic               arr_buf,
  output logic               arr_block,
  output logic               arr_commit
);
  localparam int unsigned T_MAX1 = (T_XFER > T_ERASE) ? T_XFER : T_ERASE;
  localparam int unsigned T_MAX2 = (T_BLK > T_PROG) ? T_BLK : T_PROG;
  localparam int unsigned T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
  localparam int unsigned CW     = $clog2(T_MAX + 1);
  localparam logic [PAGE_AW-1:0] BLK_MASK = ~(PAGE_AW'((1 << BLK_SHIFT) - 1));
  localparam logic [PAGE_AW:0]   PROT_LIM = (PAGE_AW + 1)'(PROT_PAGES);

  // decoded command
  plan_t plan;
  nvmseq_decode u_dec (.op_i(cmd_op), .plan_o(plan));

  // sequencer state
  phase_e             ph_q, ph2_q;
  logic [PAGE_AW-1:0] page_q;
  logic               bsel_q, blk_q, comp_q;

  // named internal events
  logic          accept, tmr_zero, ph_end, cmp_last, chain, wr_blocked, tmr_load;
  logic [CW-1:0] tmr_val;

  assign accept     = cmd_valid && plan.arr && (ph_q == PH_IDLE);
  assign ph_end     = (ph_q != PH_IDLE) && tmr_zero;
  assign chain      = ph_end && (ph2_q != PH_IDLE);
  assign cmp_last   = ph_end && (ph_q == PH_CMP);
  assign wr_blocked = ((ph_q == PH_ERASE) || (ph_q == PH_PROG)) && !wp_n &&
                      ({1'b0, page_q} < PROT_LIM);

  always_comb begin
    tmr_load = accept || chain;
    if (accept)
      tmr_val = CW'(phase_len(plan.first, plan.blk, T_XFER, T_ERASE, T_BLK, T_PROG) - 1);
    else
      tmr_val = CW'(phase_len(ph2_q, blk_q, T_XFER, T_ERASE, T_BLK, T_PROG) - 1);
  end

  nvmseq_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .zero_o(tmr_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      ph2_q  <= PH_IDLE;
      page_q <= '0;
      bsel_q <= 1'b0;
      blk_q  <= 1'b0;
    end else if (accept) begin
      ph_q   <= plan.first;
      ph2_q  <= plan.second;
      page_q <= plan.blk ? (cmd_page & BLK_MASK) : cmd_page;
      bsel_q <= plan.bsel;
      blk_q  <= plan.blk;
    end else if (chain) begin
      ph_q   <= ph2_q;
      ph2_q  <= PH_IDLE;
    end else if (ph_end) begin
      ph_q   <= PH_IDLE;
      blk_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        comp_q <= 1'b0;
    else if (cmp_last) comp_q <= cmp_miss;
  end

  assign status_o     = {ph_q == PH_IDLE, comp_q, DENSITY_CODE, 3'b000};
  assign busy_pull_en = (ph_q != PH_IDLE);
  assign arr_phase    = ph_q;
  assign arr_page     = page_q;
  assign arr_buf      = bsel_q;
  assign arr_block    = blk_q && (ph_q != PH_IDLE);
  assign arr_commit   = ph_end && !wr_blocked;

  nvmseq_status_ser #(.W(8)) u_ser (
    .clk(clk), .rst_n(rst_n), .word_i(status_o), .load_i(st_load),
    .shift_i(st_shift), .bit_o(st_bit)
  );

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_pull_en); // R2
  AST_COMMIT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_commit |-> (arr_phase != 3'd0)); // R2
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && $past(ph_q) != PH_IDLE) |-> $stable(page_q)); // R3
  AST_PROG_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PROG && $past(ph_q) != PH_PROG && $past(ph_q) != PH_IDLE)
      |-> $past(tmr_zero)); // R5
  AST_BLOCK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    arr_block |-> ((arr_page & ~BLK_MASK) == '0)); // R7
  AST_CMP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(comp_q) |-> $past(cmp_last)); // R8
  AST_WP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_commit && (arr_phase == 3'd3 || arr_phase == 3'd4))
      |-> (wp_n || {1'b0, arr_page} >= PROT_LIM)); // R9
endmodule

// File: tb/nvm_op_sequencer_test.sv
module nvm_op_sequencer_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic [11:0] cmd_page = '0;
  logic wp_n = 1'b1, cmp_miss = 1'b0, st_load = 1'b0, st_shift = 1'b0;
  logic st_bit, busy_pull_en, arr_buf, arr_block, arr_commit;
  logic [7:0] status_o;
  logic [2:0] arr_phase;
  logic [11:0] arr_page;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  nvm_op_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_page(cmd_page), .wp_n(wp_n), .cmp_miss(cmp_miss), .st_load(st_load),
    .st_shift(st_shift), .st_bit(st_bit), .status_o(status_o),
    .busy_pull_en(busy_pull_en), .arr_phase(arr_phase), .arr_page(arr_page),
    .arr_buf(arr_buf), .arr_block(arr_block), .arr_commit(arr_commit)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [11:0] page;
    logic        wp;
    logic        miss;
    int          len;
    logic [2:0]  ph_first;
    logic [2:0]  ph_last;
    int          commits;
    logic [11:0] epage;
    logic        ebuf;
    logic        eblk;
    logic [7:0]  estat;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'h53, 12'd5,   1'b1, 1'b0,  6, 3'd1, 3'd1, 1, 12'd5,   1'b0, 1'b0, 8'hA8},
    '{8'h55, 12'd300, 1'b1, 1'b0,  6, 3'd1, 3'd1, 1, 12'd300, 1'b1, 1'b0, 8'hA8},
    '{8'h83, 12'd10,  1'b1, 1'b0, 24, 3'd3, 3'd4, 2, 12'd10,  1'b0, 1'b0, 8'hA8},
    '{8'h86, 12'd10,  1'b0, 1'b0, 24, 3'd3, 3'd4, 0, 12'd10,  1'b1, 1'b0, 8'hA8},
    '{8'h86, 12'd256, 1'b0, 1'b0, 24, 3'd3, 3'd4, 2, 12'd256, 1'b1, 1'b0, 8'hA8},
    '{8'h58, 12'd3,   1'b1, 1'b0, 20, 3'd1, 3'd4, 2, 12'd3,   1'b0, 1'b0, 8'hA8},
    '{8'h59, 12'd3,   1'b0, 1'b0, 20, 3'd1, 3'd4, 1, 12'd3,   1'b1, 1'b0, 8'hA8},
    '{8'h50, 12'h123, 1'b1, 1'b0, 20, 3'd3, 3'd3, 1, 12'h120, 1'b0, 1'b1, 8'hA8},
    '{8'h81, 12'd7,   1'b0, 1'b0, 10, 3'd3, 3'd3, 0, 12'd7,   1'b0, 1'b0, 8'hA8},
    '{8'h88, 12'd9,   1'b1, 1'b0, 14, 3'd4, 3'd4, 1, 12'd9,   1'b0, 1'b0, 8'hA8},
    '{8'h60, 12'd40,  1'b1, 1'b1,  6, 3'd2, 3'd2, 1, 12'd40,  1'b0, 1'b0, 8'hE8},
    '{8'h54, 12'd0,   1'b1, 1'b1,  0, 3'd0, 3'd0, 0, 12'd0,   1'b0, 1'b0, 8'hE8},
    '{8'h61, 12'd41,  1'b1, 1'b0,  6, 3'd2, 3'd2, 1, 12'd41,  1'b1, 1'b0, 8'hA8},
    '{8'h57, 12'd0,   1'b1, 1'b0,  0, 3'd0, 3'd0, 0, 12'd0,   1'b0, 1'b0, 8'hA8},
    '{8'h00, 12'd0,   1'b1, 1'b0,  0, 3'd0, 3'd0, 0, 12'd0,   1'b0, 1'b0, 8'hA8},
    '{8'h82, 12'd500, 1'b0, 1'b0, 24, 3'd3, 3'd4, 2, 12'd500, 1'b0, 1'b0, 8'hA8}
  };

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'h53, 8'h55, 8'h88, 8'h89, 8'h81: return "R12";
      8'h83, 8'h86, 8'h82, 8'h85:        return "R5";
      8'h58, 8'h59:                      return "R6";
      8'h50:                             return "R7";
      8'h60, 8'h61:                      return "R8";
      default:                           return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // observed results of one operation
  int o_len, o_commits, o_mis;
  logic [2:0] o_first, o_last;
  logic [11:0] o_page;
  logic o_buf, o_blk;
  bit o_page_moved;

  // issue one command, then watch the busy window (sampled on falling edges)
  task automatic issue_and_watch(input logic [7:0] op, input logic [11:0] pg,
                                 input bit inject);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_page = pg;
    @(negedge clk);
    cmd_valid = 1'b0;
    o_len = 0; o_commits = 0; o_mis = 0; o_page_moved = 1'b0;
    o_first = 3'd0; o_last = 3'd0; o_page = '0; o_buf = 1'b0; o_blk = 1'b0;
    while (busy_pull_en && o_len < 400) begin
      if (o_len == 0) begin
        o_first = arr_phase; o_page = arr_page; o_buf = arr_buf; o_blk = arr_block;
      end else if (arr_page != o_page) o_page_moved = 1'b1;
      o_last = arr_phase;
      if (arr_commit) o_commits++;
      if (busy_pull_en != !status_o[7]) o_mis++;
      o_len++;
      cmd_valid = 1'b0;
      if (inject && o_len == 3) begin cmd_valid = 1'b1; cmd_op = 8'h53; cmd_page = 12'd99; cmp_miss = 1'b1; end
      if (inject && o_len == 4) begin cmd_valid = 1'b1; cmd_op = 8'h60; cmd_page = 12'd98; end
      if (inject && o_len == 5) begin cmd_valid = 1'b1; cmd_op = 8'h84; end
      if (inject && o_len == 6) begin cmd_valid = 1'b1; cmd_op = 8'h57; end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
  endtask

  initial begin : watchdog
    #(PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] sb;
    logic b9;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(status_o == 8'hA8, "R1", "status after reset", status_o, 8'hA8);
    check(busy_pull_en == 1'b0 && arr_phase == 3'd0 && arr_commit == 1'b0,
          "R1", "idle after reset", {busy_pull_en, arr_phase, arr_commit}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wp_n = VECS[i].wp; cmp_miss = VECS[i].miss;
      issue_and_watch(VECS[i].op, VECS[i].page, 1'b0);
      check(o_len == VECS[i].len, req_of(VECS[i].op), "busy length", o_len, VECS[i].len);
      check(o_mis == 0, "R2", "busy pin vs status bit 7", o_mis, 0);
      check(status_o == VECS[i].estat, (VECS[i].op[7:1] == 7'h30) ? "R8" : "R1",
            "status after op", status_o, VECS[i].estat);
      if (VECS[i].len != 0) begin
        check(o_first == VECS[i].ph_first, req_of(VECS[i].op), "first phase", o_first, VECS[i].ph_first);
        check(o_last == VECS[i].ph_last, req_of(VECS[i].op), "last phase", o_last, VECS[i].ph_last);
        check(o_commits == VECS[i].commits, "R9", "commit count", o_commits, VECS[i].commits);
        check(o_page == VECS[i].epage && !o_page_moved, req_of(VECS[i].op), "page", o_page, VECS[i].epage);
        check(o_buf == VECS[i].ebuf, "R12", "buffer select", o_buf, VECS[i].ebuf);
        check(o_blk == VECS[i].eblk, "R7", "block flag", o_blk, VECS[i].eblk);
      end
      wp_n = 1'b1; cmp_miss = 1'b0;
    end

    // R3: array commands while busy are dropped, buffer commands pass
    issue_and_watch(8'h83, 12'd20, 1'b1);
    cmp_miss = 1'b0;
    check(o_len == 24, "R3", "length with injected commands", o_len, 24);
    check(!o_page_moved && o_page == 12'd20, "R3", "page held", o_page, 20);
    check(o_commits == 2, "R3", "commits with injected commands", o_commits, 2);
    check(status_o == 8'hA8, "R3", "status untouched by dropped compare", status_o, 8'hA8);

    // R10: reset aborts operation and clears compare bit
    cmp_miss = 1'b1;
    issue_and_watch(8'h60, 12'd1, 1'b0);
    cmp_miss = 1'b0;
    check(status_o == 8'hE8, "R8", "compare mismatch latched", status_o, 8'hE8);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 8'h86; cmd_page = 12'd400;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy_pull_en == 1'b0 && arr_phase == 3'd0, "R10", "abort on reset",
          {busy_pull_en, arr_phase}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    begin
      int late = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (arr_commit || busy_pull_en) late++;
      end
      check(late == 0, "R10", "no activity after abort", late, 0);
    end
    check(status_o == 8'hA8, "R10", "status after abort", status_o, 8'hA8);

    // R11: serial status readout with wrap
    @(negedge clk); st_load = 1'b1;
    @(negedge clk); st_load = 1'b0;
    sb = '0; b9 = 1'b0;
    for (int k = 0; k < 9; k++) begin
      if (k < 8) sb = {sb[6:0], st_bit}; else b9 = st_bit;
      st_shift = 1'b1;
      @(negedge clk);
    end
    st_shift = 1'b0;
    check(sb == 8'hA8, "R11", "serial byte", sb, 8'hA8);
    check(b9 == 1'b1, "R11", "wrap to bit 7", b9, 1);

    // R11: live bit 7 while polling across a busy window
    cmd_valid = 1'b1; cmd_op = 8'h88; cmd_page = 12'd600; st_load = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; st_load = 1'b0;
    check(st_bit == 1'b0, "R11", "polled bit while busy", st_bit, 0);
    repeat (20) @(negedge clk);
    check(st_bit == 1'b1, "R11", "polled bit after completion", st_bit, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule